// File: doc/BRIEF.md
# Key-Guarded Flash Erase and Row-Program Controller

This block sits between a single-master register port and an on-chip nonvolatile memory model. It lets software erase an aligned block of eight rows or program one row of 128 32-bit words, and it does so only after an unlock handshake. Software writes two fixed key words, one after the other, and then sets the start bit through a set-only alias of the control register. Any other pattern is refused and flagged as a write error.

A launched operation walks the memory one word per clock. An erase forces every word of the block to all ones. A program reads each source word from data RAM, beginning at the source address register, and ANDs it into the addressed row, so that a bit can only go from one to zero. After the walk a settle delay models the physical write time. The busy bit stays set for the walk and the delay and then clears by itself. While busy, register writes are dropped.

Top module: `flash_keyed_ctrl`

## Requirements
- R1: After reset every register reads as zero, including the busy bit, the two error bits (13 and 12) and both address registers. The low-voltage error bit 12 always reads zero.
- R2: An operation launches only when the key register receives 0xAA996655 on one bus access and 0x556699AA on the very next access, and the access right after that is a set-alias write with bit 15 set. Any other order, any wrong value, or any access between these three steps disarms the unlock. A start attempt consumes the unlock whether or not it launches.
- R3: Operation code 4 with a block-aligned target forces all 1024 words of that 8-row block to 0xFFFFFFFF and leaves every other word unchanged.
- R4: A start attempt with write-enable bit 14 clear, with an operation code other than 3 or 4, or without a valid unlock sets write-error bit 13 and starts nothing.
- R5: Operation code 3 with a row-aligned target replaces each word i (0 to 127) of the row by its old value ANDed with the data-RAM word at byte address source + 4*i.
- R6: Busy bit 15 stays set for exactly 128 + PROG_WAIT cycles for a row program and 1024 + ERASE_WAIT cycles for a block erase, and then clears without software action.
- R7: While busy, writes to any register, key or alias are ignored.
- R8: A target byte address that is not aligned to 512 bytes for a program or to 4096 bytes for an erase, or that lies outside the memory, is rejected as in R4 and leaves the memory unchanged.
- R9: Register offsets are control 0, control set-alias 1, key 2, target address 3, source address 4. A plain control write loads bits 14 and 3:0, clears bit 13 and never starts an operation even when bit 15 is set. A set-alias write ORs bits 14 and 3:0 into the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register, combinational |
| ram_addr | output | 32 | Byte address of the source word being read from data RAM |
| ram_rdata | input | 32 | Data RAM word at ram_addr, combinational |
| fl_ridx | input | FLASH_AW | Word index for reading the memory model |
| fl_rdata | output | 32 | Memory model word at fl_ridx |

## Verification
The unlock is tried with the correct key pair, with a wrong second key, with the keys swapped, with a read slipped between the keys, and with a second start that reuses a spent unlock. This separates a state machine that advances on every access from one that only watches key writes. Programs are run on an erased row and then again on the same row with different data, which tells a bitwise AND apart from a plain overwrite. Targets aligned to a row but not to a block, off by one word, and past the end of the memory show that each operation checks its own alignment unit.

// File: rtl/flash_keyed_pkg.sv
package flash_keyed_pkg;

    localparam logic [31:0] KEY_FIRST  = 32'hAA996655;
    localparam logic [31:0] KEY_SECOND = 32'h556699AA;

    localparam int BIT_START = 15;
    localparam int BIT_WREN  = 14;
    localparam int BIT_WRERR = 13;

    localparam logic [3:0] OP_ROWPROG  = 4'd3;
    localparam logic [3:0] OP_BLKERASE = 4'd4;

    typedef enum logic [2:0] {
        REG_CTRL     = 3'd0,
        REG_CTRL_SET = 3'd1,
        REG_KEY      = 3'd2,
        REG_TADDR    = 3'd3,
        REG_SADDR    = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        UL_LOCKED,
        UL_HALF,
        UL_ARMED
    } unlock_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SWEEP,
        ENG_SETTLE
    } eng_phase_e;

    typedef struct packed {
        logic        valid;
        logic        erase;
        logic [31:0] idx;
    } mem_wr_t;

    function automatic logic low_bits_clear(logic [31:0] a, int shift);
        logic [31:0] mask;
        mask = (32'd1 << shift) - 32'd1;
        return (a & mask) == 32'd0;
    endfunction

endpackage

// File: rtl/fk_unlock.sv
module fk_unlock
    import flash_keyed_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc,
    input  logic        key_wr,
    input  logic [31:0] wdata,
    output logic        armed
);

    unlock_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= UL_LOCKED;
        end else if (acc) begin
            if (state == UL_HALF && key_wr && wdata == KEY_SECOND)
                state <= UL_ARMED;
            else if (state != UL_HALF && key_wr && wdata == KEY_FIRST)
                state <= UL_HALF;
            else
                state <= UL_LOCKED;
        end
    end

    assign armed = (state == UL_ARMED);

    // R2: arming only follows the second key
    a_r2_armed_after_second_key: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(acc && key_wr && wdata == KEY_SECOND));

    // R2: any access while armed spends the unlock
    a_r2_access_disarms: assert property (@(posedge clk) disable iff (rst)
        (armed && acc) |=> !armed);

endmodule

// File: rtl/fk_engine.sv
module fk_engine
    import flash_keyed_pkg::*;
#(
    parameter int ROW_WORDS  = 128,
    parameter int BLK_WORDS  = 1024,
    parameter int ERASE_WAIT = 40,
    parameter int PROG_WAIT  = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        erase,
    input  logic [31:0] base_idx,
    output logic        busy,
    output logic [31:0] step,
    output mem_wr_t     wr
);

    localparam logic [31:0] ROW_LAST  = 32'(ROW_WORDS - 1);
    localparam logic [31:0] BLK_LAST  = 32'(BLK_WORDS - 1);
    localparam logic [31:0] EW_LAST   = 32'(ERASE_WAIT - 1);
    localparam logic [31:0] PW_LAST   = 32'(PROG_WAIT - 1);

    eng_phase_e  phase;
    logic [31:0] cnt;
    logic        is_erase;
    logic [31:0] base;
    logic [31:0] sweep_last;
    logic        no_wait;
    logic [31:0] wait_last;

    assign sweep_last = is_erase ? BLK_LAST : ROW_LAST;
    assign no_wait    = is_erase ? (ERASE_WAIT == 0) : (PROG_WAIT == 0);
    assign wait_last  = is_erase ? EW_LAST : PW_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ENG_IDLE;
            cnt      <= '0;
            is_erase <= 1'b0;
            base     <= '0;
        end else begin
            case (phase)
                ENG_IDLE: if (start) begin
                    phase    <= ENG_SWEEP;
                    cnt      <= '0;
                    is_erase <= erase;
                    base     <= base_idx;
                end
                ENG_SWEEP: if (cnt == sweep_last) begin
                    cnt   <= '0;
                    phase <= no_wait ? ENG_IDLE : ENG_SETTLE;
                end else begin
                    cnt <= cnt + 32'd1;
                end
                ENG_SETTLE: if (cnt == wait_last) begin
                    cnt   <= '0;
                    phase <= ENG_IDLE;
                end else begin
                    cnt <= cnt + 32'd1;
                end
                default: phase <= ENG_IDLE;
            endcase
        end
    end

    assign busy     = (phase != ENG_IDLE);
    assign step     = cnt;
    assign wr.valid = (phase == ENG_SWEEP);
    assign wr.erase = is_erase;
    assign wr.idx   = base + cnt;

    // R7: the top never launches into a running operation
    a_r7_start_only_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> phase == ENG_IDLE);

    // R6: the walk never runs past its unit
    a_r6_sweep_bounded: assert property (@(posedge clk) disable iff (rst)
        (phase == ENG_SWEEP) |-> cnt <= sweep_last);

endmodule

// File: rtl/fk_array.sv
module fk_array
    import flash_keyed_pkg::*;
#(
    parameter int WORDS = 2048,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_valid,
    input  logic          wr_erase,
    input  logic [AW-1:0] wr_idx,
    input  logic [31:0]   wr_src,
    input  logic [AW-1:0] rd_idx,
    output logic [31:0]   rd_data
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_valid)
            mem[wr_idx] <= wr_erase ? 32'hFFFF_FFFF : (mem[wr_idx] & wr_src);
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/flash_keyed_ctrl.sv
module flash_keyed_ctrl
    import flash_keyed_pkg::*;
#(
    parameter int ROW_WORDS    = 128,
    parameter int ROWS_PER_BLK = 8,
    parameter int NUM_BLKS     = 2,
    parameter int ERASE_WAIT   = 40,
    parameter int PROG_WAIT    = 20,
    localparam int BLK_WORDS   = ROW_WORDS * ROWS_PER_BLK,
    localparam int FLASH_WORDS = BLK_WORDS * NUM_BLKS,
    localparam int FLASH_AW    = $clog2(FLASH_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [31:0]         ram_addr,
    input  logic [31:0]         ram_rdata,
    input  logic [FLASH_AW-1:0] fl_ridx,
    output logic [31:0]         fl_rdata
);

    localparam int          ROW_SHIFT   = $clog2(ROW_WORDS) + 2;
    localparam int          BLK_SHIFT   = $clog2(BLK_WORDS) + 2;
    localparam logic [31:0] FLASH_BYTES = 32'(FLASH_WORDS * 4);

    logic        wren, wrerr;
    logic [3:0]  op;
    logic [31:0] taddr, saddr;

    logic        busy, armed;
    logic [31:0] step;
    mem_wr_t     mwr;

    logic        wr_ok, key_wr, start_try, launch;
    logic        wren_eff, tgt_ok, is_erase_op, is_prog_op;
    logic [3:0]  op_eff;

    assign wr_ok     = bus_sel && bus_wr && !busy;
    assign key_wr    = wr_ok && bus_addr == REG_KEY;
    assign start_try = wr_ok && bus_addr == REG_CTRL_SET && bus_wdata[BIT_START];

    assign op_eff      = op | bus_wdata[3:0];
    assign wren_eff    = wren | bus_wdata[BIT_WREN];
    assign is_erase_op = (op_eff == OP_BLKERASE);
    assign is_prog_op  = (op_eff == OP_ROWPROG);

    always_comb begin
        tgt_ok = 1'b0;
        if (taddr < FLASH_BYTES) begin
            if (is_erase_op)
                tgt_ok = low_bits_clear(taddr, BLK_SHIFT);
            else if (is_prog_op)
                tgt_ok = low_bits_clear(taddr, ROW_SHIFT);
        end
    end

    assign launch = start_try && armed && wren_eff && tgt_ok;

    fk_unlock u_unlock (
        .clk   (clk),
        .rst   (rst),
        .acc   (bus_sel),
        .key_wr(key_wr),
        .wdata (bus_wdata),
        .armed (armed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wren  <= 1'b0;
            wrerr <= 1'b0;
            op    <= '0;
            taddr <= '0;
            saddr <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                REG_CTRL: begin
                    wren  <= bus_wdata[BIT_WREN];
                    op    <= bus_wdata[3:0];
                    wrerr <= 1'b0;
                end
                REG_CTRL_SET: begin
                    wren <= wren_eff;
                    op   <= op_eff;
                    if (start_try && !launch)
                        wrerr <= 1'b1;
                end
                REG_TADDR: taddr <= bus_wdata;
                REG_SADDR: saddr <= bus_wdata;
                default: ;
            endcase
        end
    end

    fk_engine #(
        .ROW_WORDS (ROW_WORDS),
        .BLK_WORDS (BLK_WORDS),
        .ERASE_WAIT(ERASE_WAIT),
        .PROG_WAIT (PROG_WAIT)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (launch),
        .erase   (is_erase_op),
        .base_idx(taddr >> 2),
        .busy    (busy),
        .step    (step),
        .wr      (mwr)
    );

    assign ram_addr = saddr + (step << 2);

    fk_array #(.WORDS(FLASH_WORDS)) u_array (
        .clk     (clk),
        .wr_valid(mwr.valid),
        .wr_erase(mwr.erase),
        .wr_idx  (mwr.idx[FLASH_AW-1:0]),
        .wr_src  (ram_rdata),
        .rd_idx  (fl_ridx),
        .rd_data (fl_rdata)
    );

    always_comb begin
        case (bus_addr)
            REG_CTRL, REG_CTRL_SET:
                bus_rdata = {16'd0, busy, wren, wrerr, 1'b0, 8'd0, op};
            REG_TADDR: bus_rdata = taddr;
            REG_SADDR: bus_rdata = saddr;
            default:   bus_rdata = 32'd0;
        endcase
    end

    // R4: a refused start raises the write error and stays idle
    a_r4_reject_flags: assert property (@(posedge clk) disable iff (rst)
        (start_try && !launch) |=> (wrerr && !busy));

    // R7: the target register holds while an operation runs
    a_r7_taddr_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_sel && bus_wr && bus_addr == REG_TADDR) |=> $stable(taddr));

    // R6: a launch raises busy on the next cycle
    a_r6_launch_busy: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

    // R8: memory writes only land inside the array
    a_r8_write_in_range: assert property (@(posedge clk) disable iff (rst)
        mwr.valid |-> mwr.idx < 32'(FLASH_WORDS));

endmodule

// File: tb/flash_keyed_ctrl_test.sv
module flash_keyed_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam logic [31:0] K1 = 32'hAA996655;
    localparam logic [31:0] K2 = 32'h556699AA;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, ram_addr, ram_rdata, fl_rdata;
    logic [AW-1:0] fl_ridx = '0;
    logic [31:0] ram [256];

    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign ram_rdata = ram[ram_addr[9:2]];

    flash_keyed_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .fl_ridx(fl_ridx), .fl_rdata(fl_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(int idx, output logic [31:0] d);
        fl_ridx = AW'(idx);
        #1 d = fl_rdata;
    endtask

    // counts read samples that show busy, starting right after a launch
    task automatic wait_idle(output int n);
        logic [31:0] c;
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd0, c);
            if (!c[15]) break;
            n++;
        end
    endtask

    task automatic start_op(logic [31:0] ctrl, logic [31:0] tgt);
        wr(3'd0, ctrl);
        wr(3'd3, tgt);
        wr(3'd2, K1);
        wr(3'd2, K2);
        wr(3'd1, 32'h8000);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd0, d); check("R1 ctrl", d, 32'h0);
        rd(3'd3, d); check("R1 taddr", d, 32'h0);
        rd(3'd4, d); check("R1 saddr", d, 32'h0);
    endtask

    task automatic t_erase;
        logic [31:0] d; int n;
        start_op(32'h4004, 32'h0);
        wait_idle(n);
        check("R6 erase busy cycles", 32'(n), 32'(1024 + 40));
        rd(3'd0, d); check("R3 no error", d, 32'h0000_4004);
        peek(0, d);    check("R3 first word", d, 32'hFFFFFFFF);
        peek(1023, d); check("R3 last word", d, 32'hFFFFFFFF);
        start_op(32'h4004, 32'h1000);
        wait_idle(n);
        peek(1024, d); check("R3 second block", d, 32'hFFFFFFFF);
    endtask

    task automatic t_program;
        logic [31:0] d; int n;
        for (int i = 0; i < 256; i++) ram[i] = 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101);
        wr(3'd4, 32'h100);
        start_op(32'h4003, 32'h200);
        wait_idle(n);
        check("R6 program busy cycles", 32'(n), 32'(128 + 20));
        peek(128, d); check("R5 row word 0", d, ram[64]);
        peek(200, d); check("R5 row word 72", d, ram[136]);
        peek(255, d); check("R5 row word 127", d, ram[191]);
        peek(127, d); check("R5 word before row", d, 32'hFFFFFFFF);
        peek(256, d); check("R5 word after row", d, 32'hFFFFFFFF);
        for (int i = 0; i < 256; i++) ram[i] = 32'h0F0F_F0F0 ^ 32'(i);
        wr(3'd4, 32'h0);
        start_op(32'h4003, 32'h200);
        wait_idle(n);
        peek(130, d);
        check("R5 second program ANDs", d, (32'hA5A5_0000 ^ (32'd66 * 32'h0101_0101)) & (32'h0F0F_F0F0 ^ 32'd2));
    endtask

    task automatic t_bad_unlock;
        logic [31:0] d;
        wr(3'd0, 32'h4004); wr(3'd3, 32'h1000);
        wr(3'd2, K1); wr(3'd2, 32'h556699AB); wr(3'd1, 32'h8000);
        rd(3'd0, d); check("R2 wrong key refused", d, 32'h0000_6004);
        wr(3'd0, 32'h4004);
        wr(3'd2, K2); wr(3'd2, K1); wr(3'd1, 32'h8000);
        rd(3'd0, d); check("R2 swapped keys refused", d, 32'h0000_6004);
        wr(3'd0, 32'h4004);
        wr(3'd2, K1); rd(3'd3, d); wr(3'd2, K2); wr(3'd1, 32'h8000);
        rd(3'd0, d); check("R2 access between keys refused", d, 32'h0000_6004);
        wr(3'd0, 32'h4004);
        wr(3'd2, K1); wr(3'd2, K2); rd(3'd3, d); wr(3'd1, 32'h8000);
        rd(3'd0, d); check("R2 access before start refused", d, 32'h0000_6004);
        peek(1024, d); check("R2 memory untouched", d, 32'hFFFFFFFF);
    endtask

    task automatic t_bad_ctrl;
        logic [31:0] d; int n;
        start_op(32'h0003, 32'h200);
        rd(3'd0, d); check("R4 no write enable", d, 32'h0000_2003);
        start_op(32'h4005, 32'h0);
        rd(3'd0, d); check("R4 bad opcode", d, 32'h0000_6005);
        wr(3'd0, 32'hC004);
        rd(3'd0, d); check("R9 plain write clears error, no start", d, 32'h0000_4004);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0000_4003);
        rd(3'd0, d); check("R9 set alias ORs bits", d, 32'h0000_4003);
        start_op(32'h4004, 32'h1000);
        wait_idle(n);
        wr(3'd1, 32'h8000);
        rd(3'd0, d); check("R2 unlock spent by start", d, 32'h0000_6004);
    endtask

    task automatic t_align;
        logic [31:0] d;
        start_op(32'h4003, 32'h1204);
        rd(3'd0, d); check("R8 unaligned program", d, 32'h0000_6003);
        start_op(32'h4004, 32'h200);
        rd(3'd0, d); check("R8 row-aligned erase refused", d, 32'h0000_6004);
        peek(128, d); check("R8 memory unchanged", d, ram[64] & 32'h0F0F_F0F0 | 32'h0 ? (32'hA5A5_0000 ^ (32'd64 * 32'h0101_0101)) & (32'h0F0F_F0F0 ^ 32'd0) : 32'h0);
        start_op(32'h4004, 32'h2000);
        rd(3'd0, d); check("R8 out of range erase", d, 32'h0000_6004);
    endtask

    task automatic t_busy_ignores;
        logic [31:0] d; int n;
        wr(3'd4, 32'h0);
        start_op(32'h4003, 32'h1200);
        wr(3'd3, 32'h0400);
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h80);
        wait_idle(n);
        rd(3'd3, d); check("R7 taddr kept", d, 32'h1200);
        rd(3'd4, d); check("R7 saddr kept", d, 32'h0);
        rd(3'd0, d); check("R7 ctrl kept", d, 32'h0000_4003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_erase();
        t_program();
        t_bad_unlock();
        t_bad_ctrl();
        t_align();
        t_busy_ignores();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule